// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block is the digital control core for a bank of eight on/off channels. A host drives three wires: an active-low frame select, a serial clock and a data line. While a frame is open, each falling edge of the serial clock moves one data bit into an 8-bit shift register. When frame select returns high, the shift register contents are copied into the channel-enable register. That register drives one enable output per channel.

The bits that leave the top of the shift register appear on a serial output. The output is updated on the rising serial clock edge, so it is stable at the next falling edge. A downstream device of the same kind can therefore take it as its data input. The same output lets a host read back what was loaded.

All three serial wires are brought through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are detected on the synchronized copies. The serial output is modelled as a pull-down enable plus a plain logic copy.

Top module: `swc_top`

## Requirements
- R1: While frame select is high, serial clock and data activity changes neither the shift register nor the serial output.
- R2: During a frame, each falling serial clock edge shifts the register up by one and puts the data bit into bit 0.
- R3: Channel-enable output bit i follows register bit i, so the first of eight bits sent (MSB) controls `chan_en[7]`; a 1 enables the channel and a 0 disables it.
- R4: A frame may carry any number of clocks, and the register then holds the last eight bits received, oldest in bit 7.
- R5: `chan_en` changes only when frame select rises. At that point it takes the register value.
- R6: `sdo_data` takes register bit 7 on each rising serial clock edge inside a frame, so a bit reappears there after eight falling edges.
- R7: While `rst_n` is low, the channels, the shift register and `sdo_data` all clear to 0, and they stay cleared until a frame loads new data.
- R8: `sdo_pull_low` is asserted exactly when `sdo_data` is 0.
- R9: A frame with no serial clocks still commits the unchanged register to `chan_en`.
- R10: A falling serial clock edge that reaches the synchronized domain in the same cycle as the rising frame select is not shifted. The commit uses the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo_pull_low | output | 1 | Drive-low enable for the open-drain serial output |
| sdo_data | output | 1 | Logic copy of the serial output |
| chan_en | output | 8 | Channel enables, bit i is channel i+1 |

## Verification
Two events can fall in the same synchronized cycle: the end of a frame and a falling serial clock edge. When that happens, the shift and the commit compete. The bench provokes this by lowering the serial clock and raising frame select on the same system clock edge after seven full bits. It then checks that the committed value shows only seven shifts (R10). A behavioural reference model runs against the outputs on every cycle. The model replays the raw pins through a two-deep history, and it therefore also judges the ordinary case where the two events are cycles apart.

// File: rtl/swc_pkg.sv
// Shared types and constants for the serial switch control block.
// Assumes: three serial pins are bundled into one struct so they are
// synchronized and edge-detected together.
package swc_pkg;
    typedef struct packed {
        logic frm_n;
        logic sclk;
        logic sdi;
    } serial_in_t;

    localparam int SERIAL_W = $bits(serial_in_t);
    // Idle pin state: frame closed, clock low, data low.
    localparam serial_in_t SERIAL_IDLE = '{frm_n: 1'b1, sclk: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/swc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: STAGES >= 2; reset loads RST_VAL into every stage.
module swc_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: one register stage of the synchronizer chain.
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_edges.sv
// Edge detection on the synchronized serial pins.
// Assumes: input already synchronized; one-cycle pulses are produced.
module swc_edges
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  serial_in_t s_in,
    output logic       frm_act,
    output logic       frm_rise,
    output logic       sclk_fall,
    output logic       sclk_rise,
    output logic       sdi_s
);
    serial_in_t prev;

    // Purpose: hold last cycle's synchronized pins for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= SERIAL_IDLE;
        else        prev <= s_in;
    end

    // Purpose: derive frame state and single-cycle edge pulses.
    always_comb begin
        frm_act   = ~s_in.frm_n;
        frm_rise  = ~prev.frm_n & s_in.frm_n;
        sclk_fall = prev.sclk & ~s_in.sclk;
        sclk_rise = ~prev.sclk & s_in.sclk;
        sdi_s     = s_in.sdi;
    end
endmodule

// File: rtl/swc_shift.sv
// Input shift register and delayed serial output.
// Assumes: edge pulses last one cycle; shifting and output update are
// gated by the frame being open, so a closing frame blocks a coincident edge.
module swc_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_act,
    input  logic         sclk_fall,
    input  logic         sclk_rise,
    input  logic         sdi_s,
    output logic [W-1:0] shreg,
    output logic         sdo_q
);
    // Purpose: shift a new bit in on each falling serial edge in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     shreg <= '0;
        else if (frm_act && sclk_fall)  shreg <= {shreg[W-2:0], sdi_s};
    end

    // Purpose: present the top bit on each rising serial edge in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sdo_q <= 1'b0;
        else if (frm_act && sclk_rise)  sdo_q <= shreg[W-1];
    end

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_act |=> ($stable(shreg) && $stable(sdo_q)));
    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_act && sclk_fall) |=> (shreg[0] == $past(sdi_s)));
    // R6
    sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_act && sclk_rise) |=> $stable(sdo_q));
endmodule

// File: rtl/swc_latch.sv
// Channel-enable register, loaded from the shift register at frame end.
// Assumes: frm_rise is a one-cycle pulse.
module swc_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_rise,
    input  logic [W-1:0] shreg,
    output logic [W-1:0] chan
);
    // Purpose: commit the shifted word to the channels on frame close.
    always_ff @(posedge clk) begin
        if (!rst_n)        chan <= '0;
        else if (frm_rise) chan <= shreg;
    end

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_rise |=> $stable(chan));
    // R3
    chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rise |=> (chan == $past(shreg)));
endmodule

// File: rtl/swc_top.sv
// Serial-loaded switch control register: synchronizes the three serial
// pins, shifts data on falling serial edges, returns it on rising edges
// and commits it to the channel enables when the frame closes.
// Assumes: clk is at least 4x the serial clock; rst_n is synchronous.
module swc_top
    import swc_pkg::*;
#(
    parameter int CHAN_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo_pull_low,
    output logic              sdo_data,
    output logic [CHAN_W-1:0] chan_en
);
    serial_in_t          raw_in;
    serial_in_t          sync_in;
    logic [SERIAL_W-1:0] sync_bits;
    logic                frm_act, frm_rise, sclk_fall, sclk_rise, sdi_s;
    logic [CHAN_W-1:0]   shreg;
    logic                sdo_q;

    // Purpose: bundle the raw serial pins.
    always_comb begin
        raw_in.frm_n = frm_n;
        raw_in.sclk  = sclk;
        raw_in.sdi   = sdi;
    end

    swc_sync #(
        .W       (SERIAL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SERIAL_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_bits)
    );

    assign sync_in = serial_in_t'(sync_bits);

    swc_edges edges_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (sync_in),
        .frm_act   (frm_act),
        .frm_rise  (frm_rise),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s)
    );

    swc_shift #(.W(CHAN_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_act   (frm_act),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s),
        .shreg     (shreg),
        .sdo_q     (sdo_q)
    );

    swc_latch #(.W(CHAN_W)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_rise (frm_rise),
        .shreg    (shreg),
        .chan     (chan_en)
    );

    // Purpose: open-drain style output, pulled low for a 0.
    assign sdo_data     = sdo_q;
    assign sdo_pull_low = ~sdo_q;

    // R10
    close_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_rise && sclk_fall) |=> $stable(shreg));
endmodule

// File: tb/swc_top_tb_top.sv
module swc_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo_pull_low, sdo_data;
    logic [7:0] chan_en;

    always #2.5 clk = ~clk;

    swc_top dut_i (
        .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
        .sdo_pull_low(sdo_pull_low), .sdo_data(sdo_data), .chan_en(chan_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: raw pin history, two cycles of sync latency plus edge compare.
    logic [2:0] h1 = 3'b100, h2 = 3'b100, h3 = 3'b100;   // {frm_n, sclk, sdi}
    logic [7:0] m_sreg = '0, m_chan = '0;
    logic       m_sdo = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 3'b100; h2 = 3'b100; h3 = 3'b100;
            m_sreg = '0; m_chan = '0; m_sdo = 1'b0;
        end else begin
            automatic bit act   = !h2[2];
            automatic bit fall  = h3[1] && !h2[1];
            automatic bit rise  = !h3[1] && h2[1];
            automatic bit close = !h3[2] && h2[2];
            if (close)       m_chan = m_sreg;
            if (rise && act) m_sdo  = m_sreg[7];
            if (fall && act) m_sreg = {m_sreg[6:0], h2[0]};
            h3 = h2; h2 = h1; h1 = {frm_n, sclk, sdi};
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(chan_en == m_chan, "R5 chan_en vs model", chan_en, m_chan);
            chk(sdo_data == m_sdo, "R6 sdo_data vs model", sdo_data, m_sdo);
            chk(sdo_pull_low == !sdo_data, "R8 pull_low", sdo_pull_low, !sdo_data);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] sdo_seen;

    // Send n bits MSB first; if close_on_last, frame closes with the last falling edge.
    task automatic send(input logic [31:0] bits, input int n, input bit close_on_last);
        sdo_seen = '0;
        frm_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = bits[i];
            sclk = 1'b1;
            wait_clk(4);
            sdo_seen[i] = sdo_data;
            sclk = 1'b0;
            if (i == 0 && close_on_last) frm_n = 1'b1;
            wait_clk(4);
        end
        frm_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        wait_clk(5);
        // R7 reset state
        chk(chan_en == 8'h00, "R7 reset chan_en", chan_en, 8'h00);
        chk(sdo_data == 1'b0, "R7 reset sdo_data", sdo_data, 1'b0);
        rst_n = 1'b1;
        wait_clk(3);

        // R3 eight-bit frame
        send(32'hA5, 8, 1'b0);
        chk(chan_en == 8'hA5, "R3 byte A5", chan_en, 8'hA5);
        send(32'h01, 8, 1'b0);
        chk(chan_en[0] == 1'b1 && chan_en[7:1] == 0, "R3 last bit to chan 1", chan_en, 8'h01);
        send(32'h80, 8, 1'b0);
        chk(chan_en == 8'h80, "R3 first bit to chan 8", chan_en, 8'h80);

        // R1 activity while frame closed
        send(32'h3C, 8, 1'b0);
        for (int k = 0; k < 6; k++) begin
            sdi = k[0]; sclk = ~sclk; wait_clk(4);
        end
        sclk = 1'b0; wait_clk(6);
        chk(sdo_data == 1'b0, "R1 sdo unchanged while idle", sdo_data, 1'b0);
        send(32'h0, 0, 1'b0);
        chk(chan_en == 8'h3C, "R1/R9 register kept while idle", chan_en, 8'h3C);

        // R4 long and short frames
        send(32'hF0A, 12, 1'b0);
        chk(chan_en == 8'h0A, "R4 long frame last eight", chan_en, 8'h0A);
        send(32'b101, 3, 1'b0);
        chk(chan_en == 8'h55, "R4 short frame", chan_en, 8'h55);

        // R10 closing frame coincides with last falling edge
        send(32'h00, 8, 1'b1);
        chk(chan_en == 8'h80, "R10 coincident edge dropped", chan_en, 8'h80);

        // R6 daisy chain: first byte comes back on the second byte's clocks
        send(32'hC35A, 16, 1'b0);
        chk(sdo_seen[7:0] == 8'hC3, "R6 first byte on sdo", sdo_seen[7:0], 8'hC3);
        chk(chan_en == 8'h5A, "R2 second byte kept", chan_en, 8'h5A);
        chk(sdo_pull_low == !sdo_data, "R8 open drain", sdo_pull_low, !sdo_data);

        // R9 zero-clock frame
        send(32'h0, 0, 1'b0);
        chk(chan_en == 8'h5A, "R9 empty frame", chan_en, 8'h5A);

        // R7 reset in operation clears the register too
        rst_n = 1'b0; wait_clk(2);
        chk(chan_en == 8'h00, "R7 reset clears chan_en", chan_en, 8'h00);
        chk(sdo_pull_low == 1'b1, "R7 reset pulls low", sdo_pull_low, 1'b1);
        rst_n = 1'b1; wait_clk(3);
        send(32'h0, 0, 1'b0);
        chk(chan_en == 8'h00, "R7 shift register cleared", chan_en, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule